// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits between four peripheral request lines and the address and count datapaths of a four-channel DMA engine. It conditions each incoming request by the programmed polarity and filters it through the channel masks, the controller-disable flag and the per-channel mode. It then grants one channel with a single-cycle acknowledge, which matches a transfer type that moves one byte per grant. After each grant the requests are arbitrated again at once, so a channel that keeps requesting is served on every other cycle.

A CPU-side byte port writes four configuration registers and reads one status register. The command register selects request polarity, acknowledge polarity, fixed or rotating priority, and a global disable. Each channel keeps its own mode, which is written through a shared mode register. Two mask registers give the same per-channel enable bits two ways: one sets all four at once and the other sets or clears a single channel. The status register collects terminal-count events that the datapath reports during an acknowledge, and it clears when read. The per-channel mode fields are exported so the datapath can follow direction, step and reload settings.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, the command register is 0, all four mask bits are set, every mode is 0, status reads 0x00, and no acknowledge is active (dack_out = 0000).
- R2: Writing reg_addr 2 loads the mask from wr_data[3:0], with bit i belonging to channel i. A 1 blocks that channel's requests and a 0 lets them through.
- R3: Writing reg_addr 3 sets mask bit wr_data[1:0] to the value of wr_data[2]. The other three mask bits do not change.
- R4: When command bit 4 is 0, the lowest-numbered eligible channel is granted (channel 0 highest, channel 3 lowest).
- R5: When command bit 4 is 1, priority rotates. The search starts at the channel after the last one granted and wraps from 3 to 0. After reset the last granted channel counts as 3.
- R6: Eligible requests sampled at a clock edge with no grant active produce a one-hot acknowledge for exactly one cycle, starting at that edge. The edge after an acknowledge always ends it. A request that is still held is granted again on the following edge.
- R7: When command bit 6 is set, request inputs are active low. When it is clear, they are active high.
- R8: When command bit 7 is set, acknowledge outputs are active low, so an idle dack_out is 1111. When it is clear, they are active high.
- R9: While command bit 2 is set, no new grant is made.
- R10: Writing reg_addr 1 stores wr_data[7:2] as the mode of channel wr_data[1:0], and chan_mode[6c+5:6c] shows it. Within the stored mode, bits 1:0 are the direction (11 is invalid), bit 2 selects auto-initialisation, bit 3 selects address decrement, and bits 5:4 are the transfer type (01 = single). A channel is eligible only if its type is 01 and its direction is not 11.
- R11: If tc_in[i] is high during an acknowledge of channel i and that channel does not use auto-initialisation, status bit i sets. A read of status (rd_en with reg_addr 4) clears bits 3:0 at the next edge, unless a new terminal count sets a bit at that same edge.
- R12: Status bits 7:4 show the polarity-corrected live request of channels 0 to 3, with masks and disable ignored. rd_data is 0 whenever a status read is not in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register select: 0 command, 1 mode, 2 all-mask, 3 single-mask, 4 status |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (status register) |
| dreq_in | input | 4 | Raw request lines, polarity set by command bit 6 |
| tc_in | input | 4 | Terminal count from the channel datapaths, active high |
| dack_out | output | 4 | Acknowledge lines, polarity set by command bit 7 |
| chan_mode | output | 24 | Stored 6-bit mode of each channel, channel 0 in bits 5:0 |

## Verification
The bench sweeps all 256 combinations of mask and request under fixed priority. A design with the wrong priority order, or one that ignores a mask bit, grants the wrong channel. It then walks every request pattern twice under rotating priority against a model of the last granted channel, which catches a pointer that fails to advance or wraps wrongly. Separate checks cover a single-mask write leaking into other channels, an acknowledge held for two cycles, a request that does not invert under low polarity, and a terminal count latched for an auto-initialising channel. Further checks cover a status read that leaves flags set, and a channel with block type or invalid direction being granted.

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [3:0] dreq_in,
  input  logic [3:0] tc_in,
  output logic [3:0] dack_out,
  output logic [23:0] chan_mode
);

  localparam logic [2:0] A_CMD = 3'd0, A_MODE = 3'd1, A_MASK = 3'd2, A_ONE = 3'd3, A_STAT = 3'd4;

  logic [7:0] cmd_q;
  logic [3:0] mask_q, tc_q, grant_q;
  logic [5:0] mode_q [4];
  logic [1:0] last_q;

  logic [3:0] req_live, mode_ok, cand, pick, tc_hit;
  logic [1:0] pick_idx, base;
  logic       stat_rd;

  assign req_live = dreq_in ^ {4{cmd_q[6]}};
  assign stat_rd  = rd_en && (reg_addr == A_STAT);
  assign rd_data  = stat_rd ? {req_live, tc_q} : 8'h00;
  assign dack_out = grant_q ^ {4{cmd_q[7]}};
  assign chan_mode = {mode_q[3], mode_q[2], mode_q[1], mode_q[0]};
  assign base = cmd_q[4] ? last_q + 2'd1 : 2'd0;

  for (genvar i = 0; i < 4; i++) begin : g_ch
    assign mode_ok[i] = (mode_q[i][5:4] == 2'b01) && (mode_q[i][1:0] != 2'b11);
    assign tc_hit[i]  = grant_q[i] & tc_in[i] & ~mode_q[i][2];
  end

  assign cand = req_live & ~mask_q & mode_ok & {4{~cmd_q[2]}};

  always_comb begin
    logic found;
    logic [1:0] idx;
    pick = 4'b0;
    pick_idx = 2'd0;
    found = 1'b0;
    for (int k = 0; k < 4; k++) begin
      idx = base + 2'(k);
      if (!found && cand[idx]) begin
        pick[idx] = 1'b1;
        pick_idx = idx;
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 8'h00;
      mask_q  <= 4'hF;
      tc_q    <= 4'h0;
      grant_q <= 4'h0;
      last_q  <= 2'd3;
      for (int i = 0; i < 4; i++) mode_q[i] <= 6'd0;
    end else begin
      if (wr_en) begin
        case (reg_addr)
          A_CMD:  cmd_q <= wr_data;
          A_MODE: mode_q[wr_data[1:0]] <= wr_data[7:2];
          A_MASK: mask_q <= wr_data[3:0];
          A_ONE:  mask_q[wr_data[1:0]] <= wr_data[2];
          default: ;
        endcase
      end
      if (|grant_q) grant_q <= 4'h0;
      else begin
        grant_q <= pick;
        if (|pick) last_q <= pick_idx;
      end
      tc_q <= (stat_rd ? 4'h0 : tc_q) | tc_hit;
    end
  end

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_q));
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n) (|grant_q) |=> (grant_q == 4'h0));
  p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n) (grant_q & $past(mask_q)) == 4'h0);
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n) (|grant_q) |-> !$past(cmd_q[2]));
  p_stat_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_rd) && $past(grant_q) == 4'h0) |-> (tc_q == 4'h0));

endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [3:0] dreq_in = 0, tc_in = 0, dack_out;
  logic [23:0] chan_mode;

  int tests = 0, fails = 0;
  logic rq_low = 0, ak_low = 0;
  logic [1:0] last = 2'd3;

  dma_req_arbiter dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .dreq_in(dreq_in), .tc_in(tc_in), .dack_out(dack_out),
    .chan_mode(chan_mode));

  always #10 clk = ~clk;

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    reg_addr = 3'd4; rd_en = 1; #1 v = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  function automatic logic [3:0] sel(logic [3:0] c, logic [1:0] b);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] idx;
      idx = b + 2'(k);
      if (c[idx]) return 4'(1 << idx);
    end
    return 4'h0;
  endfunction

  function automatic logic [1:0] idx_of(logic [3:0] g);
    for (int i = 0; i < 4; i++) if (g[i]) return 2'(i);
    return 2'd0;
  endfunction

  // present active-high request pattern r, expect grant g at the next edge
  task automatic try(string req, logic [3:0] r, logic [3:0] g);
    dreq_in = r ^ {4{rq_low}};
    @(negedge clk);
    check(req, {20'h0, dack_out}, {20'h0, g ^ {4{ak_low}}});
    if (g != 0) last = idx_of(g);
    dreq_in = {4{rq_low}};
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 dack", {20'h0, dack_out}, 24'h0);
    rd_stat(s);
    check("R1 status", {16'h0, s}, 24'h0);
    check("R1 mode", chan_mode, 24'h0);
    // R10 mode storage: single, read dir, ch1 auto-init
    for (int c = 0; c < 4; c++) wr(3'd1, 8'h48 | 8'(c) | (c == 1 ? 8'h10 : 8'h00));
    check("R10 chan_mode", chan_mode, {6'h12, 6'h12, 6'h16, 6'h12});
    try("R1 masked after reset", 4'hF, 4'h0);
    // R4/R2 exhaustive fixed priority
    for (int m = 0; m < 16; m++) begin
      wr(3'd2, 8'(m));
      for (int r = 0; r < 16; r++)
        try("R4/R2 fixed sweep", 4'(r), sel(4'(r) & ~4'(m), 2'd0));
    end
    // R3 single mask
    wr(3'd2, 8'h0F);
    wr(3'd3, 8'h02);
    try("R3 unmask ch2", 4'hF, 4'b0100);
    wr(3'd3, 8'h00);
    try("R3 unmask ch0", 4'hF, 4'b0001);
    wr(3'd3, 8'h04);
    try("R3 remask ch0 keeps ch2", 4'hF, 4'b0100);
    // R6 back-to-back single transfers
    wr(3'd2, 8'h00);
    dreq_in = 4'hF;
    @(negedge clk); check("R6 grant", {20'h0, dack_out}, 24'h1);
    @(negedge clk); check("R6 release", {20'h0, dack_out}, 24'h0);
    @(negedge clk); check("R6 regrant", {20'h0, dack_out}, 24'h1);
    dreq_in = 0;
    @(negedge clk);
    @(negedge clk);
    last = 2'd0;
    // R5 rotating priority sweep
    wr(3'd0, 8'h10);
    for (int p = 0; p < 2; p++)
      for (int r = 1; r < 16; r++)
        try("R5 rotate sweep", 4'(r), sel(4'(r), last + 2'd1));
    dreq_in = 4'hF;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R5 held rotation", {20'h0, dack_out}, {20'h0, sel(4'hF, last + 2'd1)});
      last = last + 2'd1;
      @(negedge clk);
    end
    dreq_in = 0;
    @(negedge clk);
    // R9 disable
    wr(3'd0, 8'h04);
    try("R9 disabled", 4'hF, 4'h0);
    wr(3'd0, 8'h00);
    try("R9 re-enabled", 4'h8, 4'h8);
    // R7/R8 polarity
    wr(3'd0, 8'hC0);
    rq_low = 1; ak_low = 1;
    dreq_in = 4'hF;
    @(negedge clk);
    check("R8 idle ack high", {20'h0, dack_out}, 24'hF);
    try("R7/R8 low polarity", 4'b0010, 4'b0010);
    try("R7 low none", 4'b0000, 4'b0000);
    dreq_in = 4'b1101;
    rd_stat(s);
    check("R12 live inverted", {16'h0, s}, {16'h0, 8'h20});
    wr(3'd0, 8'h00);
    rq_low = 0; ak_low = 0;
    dreq_in = 0;
    // R10 eligibility by mode
    wr(3'd1, 8'h88 | 8'd2);
    try("R10 block type ineligible", 4'b0100, 4'h0);
    wr(3'd1, 8'h4C | 8'd2);
    try("R10 invalid dir ineligible", 4'b0100, 4'h0);
    wr(3'd1, 8'h44 | 8'd2);
    try("R10 write dir eligible", 4'b0100, 4'b0100);
    // R11 terminal count
    dreq_in = 4'b0001;
    @(negedge clk);
    check("R11 grant ch0", {20'h0, dack_out}, 24'h1);
    tc_in = 4'b0001; dreq_in = 0;
    @(negedge clk);
    tc_in = 0;
    wr(3'd2, 8'h0D);
    dreq_in = 4'b0010;
    @(negedge clk);
    check("R11 grant ch1", {20'h0, dack_out}, 24'h2);
    tc_in = 4'b0010; dreq_in = 0;
    @(negedge clk);
    tc_in = 0;
    dreq_in = 4'b1000;
    rd_stat(s);
    check("R11/R12 status", {16'h0, s}, {16'h0, 8'h81});
    dreq_in = 0;
    rd_stat(s);
    check("R11 cleared on read", {16'h0, s}, 24'h0);
    check("R12 no read gives 0", {16'h0, rd_data}, 24'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule